// File: doc/BRIEF.md
# Interrupt-Window Request Gate

This block sits in the request path of a DMA address-translation unit and decides, one request per cycle, where a device request goes. It pays special attention to requests whose input address lands in the 1 MiB interrupt-message window at 0xFEE00000–0xFEEFFFFF. Requests that carry no process-address-space identifier (PASID) and hit that window are handed to interrupt remapping. Requests that carry a PASID get no such treatment: they are translated like any other address. If their context is in pass-through mode, they are blocked, because there is no translation step to catch them.

The route is decided combinationally from the request and its context flags. The translator's result for the same request comes in on a side input, and that result is checked as well: a translation that lands inside the interrupt window is blocked too. Every block returns an error response. Blocks that qualify for reporting raise a one-cycle registered fault strobe toward the fault recorder. The strobe carries a reason code, a PASID-present flag, the PASID value, the access direction and the faulting address.

Top module: `irq_window_gate`

## Requirements
- R1: An address lies in the interrupt window exactly when its bits [AW-1:20] equal 0xFEE, that is, when it is in the range 0xFEE00000–0xFEEFFFFF.
- R2: When `xlate_en` is 0, every valid request gets route 0 (pass), `out_addr` equals `req_addr`, `resp_err` is 0 and no fault is raised.
- R3: With `xlate_en` at 1, a request with `pasid_valid` at 0 that hits the window gets route 2 (interrupt remap). This holds whatever the value of `pass_thru`, and no fault is raised.
- R4: With `xlate_en` at 1 and `pass_thru` at 0, a request with `pasid_valid` at 1 gets route 1 (translate), even when it hits the window, and `out_addr` equals `xlat_addr`. It never gets route 2.
- R5: With `xlate_en` and `pass_thru` both at 1, a request with `pasid_valid` at 1 that hits the window gets route 3 (block) and `resp_err` at 1. The fault it reports carries reason RSN_SCALABLE (0x90), PASID-present set to 1, and its PASID value.
- R6: On a translated (route 1) request whose `xlat_addr` lies in the window, the route becomes 3 and `resp_err` goes to 1. The fault reason is 0x90 when `scalable` is 1 and RSN_LEGACY (0x0E) when it is 0. The PASID-present flag equals `pasid_valid`.
- R7: In pass-through (route 0 with `xlate_en` at 1), `out_addr` equals `req_addr` and `out_page_mask` has bits [11:0] clear and all higher bits set. On other routes `out_page_mask` is 0.
- R8: A blocked request raises `flt_valid` for exactly the single cycle after its clock edge. In that cycle `flt_write` and `flt_addr` hold the request's direction and input address.
- R9: When `fpd` is 1, a blocked request still gets route 3 and `resp_err`, but no fault strobe is raised.
- R10: A blocked access of 1 to 8 bytes (`req_size`) is reported. A blocked access of any other size still gets `resp_err` but raises no fault.
- R11: While `rst_n` is low, and after it, until a block occurs, `flt_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Request input address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 4 | Access size in bytes |
| pasid_valid | input | 1 | Request carries a PASID |
| pasid | input | PW | PASID value |
| xlate_en | input | 1 | Translation enabled globally |
| pass_thru | input | 1 | Context is in pass-through mode |
| fpd | input | 1 | Context disables fault reporting |
| scalable | input | 1 | Unit runs in scalable mode |
| xlat_addr | input | AW | Translator output for this request |
| route | output | 2 | 0 pass, 1 translate, 2 interrupt remap, 3 block |
| out_addr | output | AW | Address forwarded downstream |
| out_page_mask | output | AW | Page-base mask for pass-through |
| resp_err | output | 1 | Error response for a blocked request |
| flt_valid | output | 1 | Fault strobe |
| flt_reason | output | 8 | Fault reason code |
| flt_pasid_present | output | 1 | Fault carries a PASID |
| flt_pasid | output | PW | Faulting PASID |
| flt_write | output | 1 | Faulting access direction |
| flt_addr | output | AW | Faulting input address |

## Verification
The assertions assume that `xlat_addr` is meaningful only on cycles when a request is being translated, and that the context flags are stable for the cycle of the request they qualify. The stimulus drives each request for a single cycle, with the flags set on the same cycle, and releases `req_valid` before the next request. It sets `xlat_addr` only on the cycles where the translate path is under test. Window-edge addresses on both sides of 0xFEE00000 and 0xFEEFFFFF are driven, to probe the range decode.

// File: rtl/irq_window_gate.sv
module irq_window_gate #(
  parameter int AW = 64,
  parameter int PW = 20,
  parameter logic [11:0] WIN_BASE = 12'hFEE,
  parameter logic [7:0] RSN_LEGACY = 8'h0E,
  parameter logic [7:0] RSN_SCALABLE = 8'h90
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [3:0]    req_size,
  input  logic          pasid_valid,
  input  logic [PW-1:0] pasid,
  input  logic          xlate_en,
  input  logic          pass_thru,
  input  logic          fpd,
  input  logic          scalable,
  input  logic [AW-1:0] xlat_addr,
  output logic [1:0]    route,
  output logic [AW-1:0] out_addr,
  output logic [AW-1:0] out_page_mask,
  output logic          resp_err,
  output logic          flt_valid,
  output logic [7:0]    flt_reason,
  output logic          flt_pasid_present,
  output logic [PW-1:0] flt_pasid,
  output logic          flt_write,
  output logic [AW-1:0] flt_addr
);
  localparam int WSH = 20;
  localparam int HW = AW - WSH;
  localparam logic [HW-1:0] WIN_TAG = HW'(WIN_BASE);
  localparam logic [AW-1:0] MASK_4K = ~AW'(12'hFFF);
  localparam logic [1:0] RT_PASS = 2'd0, RT_XLAT = 2'd1, RT_IRQ = 2'd2, RT_BLOCK = 2'd3;

  logic req_hit, xlat_hit, size_ok, fault_now;
  logic [7:0] reason;

  assign req_hit  = req_addr[AW-1:WSH] == WIN_TAG;
  assign xlat_hit = xlat_addr[AW-1:WSH] == WIN_TAG;
  assign size_ok  = (req_size != 4'd0) && (req_size <= 4'd8);

  always_comb begin
    route  = RT_PASS;
    reason = RSN_SCALABLE;
    if (xlate_en) begin
      if (req_hit && !pasid_valid)
        route = RT_IRQ;
      else if (pass_thru)
        route = (req_hit && pasid_valid) ? RT_BLOCK : RT_PASS;
      else if (xlat_hit) begin
        route  = RT_BLOCK;
        reason = scalable ? RSN_SCALABLE : RSN_LEGACY;
      end else
        route = RT_XLAT;
    end
  end

  assign out_addr      = (route == RT_XLAT) ? xlat_addr :
                         (route == RT_BLOCK) ? '0 : req_addr;
  assign out_page_mask = (xlate_en && route == RT_PASS) ? MASK_4K : '0;
  assign resp_err      = req_valid && (route == RT_BLOCK);
  assign fault_now     = resp_err && size_ok && !fpd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_valid         <= 1'b0;
      flt_reason        <= '0;
      flt_pasid_present <= 1'b0;
      flt_pasid         <= '0;
      flt_write         <= 1'b0;
      flt_addr          <= '0;
    end else begin
      flt_valid <= fault_now;
      if (fault_now) begin
        flt_reason        <= reason;
        flt_pasid_present <= pasid_valid;
        flt_pasid         <= pasid_valid ? pasid : '0;
        flt_write         <= req_write;
        flt_addr          <= req_addr;
      end
    end
  end
endmodule

// File: rtl/irq_window_gate_chk.sv
module irq_window_gate_chk #(
  parameter int AW = 64,
  parameter int PW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          pasid_valid,
  input logic          xlate_en,
  input logic          pass_thru,
  input logic          fpd,
  input logic [1:0]    route,
  input logic [AW-1:0] out_addr,
  input logic          resp_err,
  input logic          flt_valid
);
  logic hit;
  assign hit = req_addr[31:20] == 12'hFEE && (AW == 32 || req_addr[AW-1:32] == '0);

  a_r2_off_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !xlate_en) |-> (route == 2'd0 && out_addr == req_addr && !resp_err));
  a_r3_nopasid_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xlate_en && !pasid_valid && hit) |-> route == 2'd2);
  a_r4_pasid_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pasid_valid) |-> route != 2'd2);
  a_r5_pt_pasid_block: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xlate_en && pass_thru && pasid_valid && hit) |-> resp_err);
  a_r8_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> $past(resp_err));
  a_r9_fpd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fpd) |=> !flt_valid);
endmodule

bind irq_window_gate irq_window_gate_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .pasid_valid(pasid_valid), .xlate_en(xlate_en), .pass_thru(pass_thru),
  .fpd(fpd), .route(route), .out_addr(out_addr), .resp_err(resp_err),
  .flt_valid(flt_valid)
);

// File: tb/test_irq_window_gate.sv
module test_irq_window_gate;
  localparam int AW = 64;
  localparam int PW = 20;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, pasid_valid = 0;
  logic xlate_en = 0, pass_thru = 0, fpd = 0, scalable = 0;
  logic [AW-1:0] req_addr = '0, xlat_addr = '0;
  logic [3:0] req_size = 4'd4;
  logic [PW-1:0] pasid = '0;
  logic [1:0] route;
  logic [AW-1:0] out_addr, out_page_mask, flt_addr;
  logic resp_err, flt_valid, flt_pasid_present, flt_write;
  logic [7:0] flt_reason;
  logic [PW-1:0] flt_pasid;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  irq_window_gate i_irq_window_gate (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [AW-1:0] a, input logic w, input logic [3:0] sz,
                       input logic pv, input logic [PW-1:0] p, input logic xe,
                       input logic pt, input logic f, input logic sc, input logic [AW-1:0] xa);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w; req_size = sz; pasid_valid = pv;
    pasid = p; xlate_en = xe; pass_thru = pt; fpd = f; scalable = sc; xlat_addr = xa;
    #1;
  endtask

  task automatic release_req;
    @(negedge clk);
    req_valid = 0; xlat_addr = '0;
  endtask

  task automatic t_reset;
    chk(flt_valid == 0, "R11 reset strobe", 64'(flt_valid), 0);
  endtask

  task automatic t_off;
    drive(64'hFEE0_0040, 1, 4, 0, 0, 0, 0, 0, 0, 0);
    chk(route == 0, "R2 route", 64'(route), 0);
    chk(out_addr == 64'hFEE0_0040, "R2 out_addr", out_addr, 64'hFEE0_0040);
    release_req();
    chk(flt_valid == 0, "R2 no fault", 64'(flt_valid), 0);
  endtask

  task automatic t_irq;
    drive(64'hFEE0_0000, 1, 4, 0, 0, 1, 0, 0, 1, 0);
    chk(route == 2, "R3 remap non-PT", 64'(route), 2);
    release_req();
    drive(64'hFEEF_FFFC, 1, 4, 0, 0, 1, 1, 0, 1, 0);
    chk(route == 2, "R3 remap PT top edge", 64'(route), 2);
    release_req();
    chk(flt_valid == 0, "R3 no fault", 64'(flt_valid), 0);
  endtask

  task automatic t_pasid_xlat;
    drive(64'hFEE0_1000, 0, 4, 1, 20'h123, 1, 0, 0, 1, 64'h8000_1000);
    chk(route == 1, "R4 window translated", 64'(route), 1);
    chk(out_addr == 64'h8000_1000, "R4 out_addr", out_addr, 64'h8000_1000);
    release_req();
  endtask

  task automatic t_edges;
    drive(64'hFEDF_FFFF, 0, 1, 0, 0, 1, 0, 0, 1, 64'h100);
    chk(route == 1, "R1 below window", 64'(route), 1);
    release_req();
    drive(64'hFEF0_0000, 0, 1, 0, 0, 1, 0, 0, 1, 64'h100);
    chk(route == 1, "R1 above window", 64'(route), 1);
    release_req();
    drive(64'h1_FEE0_0000, 0, 1, 0, 0, 1, 0, 0, 1, 64'h100);
    chk(route == 1, "R1 upper bits set", 64'(route), 1);
    release_req();
  endtask

  task automatic t_pt_block;
    drive(64'hFEE0_0010, 1, 8, 1, 20'hABCDE, 1, 1, 0, 1, 0);
    chk(route == 3, "R5 route", 64'(route), 3);
    chk(resp_err == 1, "R5 resp_err", 64'(resp_err), 1);
    chk(flt_valid == 0, "R8 not before edge", 64'(flt_valid), 0);
    release_req();
    chk(flt_valid == 1, "R8 strobe", 64'(flt_valid), 1);
    chk(flt_reason == 8'h90, "R5 reason", 64'(flt_reason), 64'h90);
    chk(flt_pasid_present == 1, "R5 present", 64'(flt_pasid_present), 1);
    chk(flt_pasid == 20'hABCDE, "R5 pasid", 64'(flt_pasid), 64'hABCDE);
    chk(flt_write == 1, "R8 write", 64'(flt_write), 1);
    chk(flt_addr == 64'hFEE0_0010, "R8 addr", flt_addr, 64'hFEE0_0010);
    @(negedge clk);
    chk(flt_valid == 0, "R8 single cycle", 64'(flt_valid), 0);
  endtask

  task automatic t_xlat_hit;
    drive(64'h4000_0000, 0, 2, 0, 0, 1, 0, 0, 0, 64'hFEE0_1000);
    chk(route == 3, "R6 route", 64'(route), 3);
    chk(resp_err == 1, "R6 resp_err", 64'(resp_err), 1);
    release_req();
    chk(flt_reason == 8'h0E, "R6 legacy reason", 64'(flt_reason), 64'h0E);
    chk(flt_pasid_present == 0, "R6 present", 64'(flt_pasid_present), 0);
    drive(64'h4000_0000, 0, 2, 1, 20'h7, 1, 0, 0, 1, 64'hFEEF_F000);
    release_req();
    chk(flt_reason == 8'h90, "R6 scalable reason", 64'(flt_reason), 64'h90);
    chk(flt_pasid_present == 1, "R6 present pasid", 64'(flt_pasid_present), 1);
  endtask

  task automatic t_pt_pass;
    drive(64'h1234_5678, 0, 4, 1, 20'h5, 1, 1, 0, 1, 0);
    chk(route == 0, "R7 route", 64'(route), 0);
    chk(out_addr == 64'h1234_5678, "R7 out_addr", out_addr, 64'h1234_5678);
    chk(out_page_mask == 64'hFFFF_FFFF_FFFF_F000, "R7 mask", out_page_mask, 64'hFFFF_FFFF_FFFF_F000);
    release_req();
  endtask

  task automatic t_fpd;
    drive(64'hFEE0_0000, 0, 4, 1, 20'h9, 1, 1, 1, 1, 0);
    chk(resp_err == 1, "R9 still error", 64'(resp_err), 1);
    release_req();
    chk(flt_valid == 0, "R9 no strobe", 64'(flt_valid), 0);
  endtask

  task automatic t_size;
    drive(64'hFEE0_0000, 0, 4'd9, 1, 20'h9, 1, 1, 0, 1, 0);
    chk(resp_err == 1, "R10 size9 error", 64'(resp_err), 1);
    release_req();
    chk(flt_valid == 0, "R10 size9 no fault", 64'(flt_valid), 0);
    drive(64'hFEE0_0000, 0, 4'd0, 1, 20'h9, 1, 1, 0, 1, 0);
    release_req();
    chk(flt_valid == 0, "R10 size0 no fault", 64'(flt_valid), 0);
    drive(64'hFEE0_0000, 0, 4'd1, 1, 20'h9, 1, 1, 0, 1, 0);
    release_req();
    chk(flt_valid == 1, "R10 size1 fault", 64'(flt_valid), 1);
  endtask

  initial begin
    #20000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_off();
    t_irq();
    t_pasid_xlat();
    t_edges();
    t_pt_block();
    t_xlat_hit();
    t_pt_pass();
    t_fpd();
    t_size();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule